// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block recovers characters from one asynchronous serial line that idles high. It runs entirely on the system clock. A phase accumulator produces a sample tick at sixteen times the bit rate, and the rate is set by the increment added each cycle. The raw line first passes through a two-flop synchronizer. A falling level starts a candidate frame. The candidate becomes a real start bit only if the line stays low until the start-bit centre, which comes eight ticks later. Each later bit is then sampled once, sixteen ticks after the previous sample.

The data bits arrive least significant first. They go into a shift register that is exactly as wide as the data bits plus the optional parity bit. After the stop-bit sample, the block presents the character for a single cycle, together with a framing-error flag and a parity-error flag. It then goes back to hunting for a start bit. Because it only re-arms after that sample, a final data bit of 0 can never open a new frame.

Top module: `uart_rx_16x`

## Requirements
- R1: While rst_ni is low, and after it is released, valid_o, frame_err_o and parity_err_o are 0 and data_o is 0. No character appears while the line stays high.
- R2: The sample tick is the carry-out of an ACC_W-bit accumulator. When USE_INC_PORT=1 the accumulator adds baud_inc_i on every clock, and otherwise it adds the parameter DEF_INC. One bit lasts 16 ticks, so a bit period of 2^(ACC_W+4)/increment clocks is received correctly, for example 32 clocks at 32768 and 64 clocks at 16384 with ACC_W=16.
- R3: A frame is a low start bit, then DATA_W data bits sent least significant first, then an optional parity bit, then a high stop bit. data_o carries the data bits with the first received bit in data_o[0], and every byte value is recovered.
- R4: Each frame yields exactly one valid_o pulse, one clock long. The flag outputs are 0 whenever valid_o is 0, and data_o only changes in a cycle where valid_o is 1.
- R5: A low pulse on the line that is shorter than half a bit (8 ticks) produces no character, and a valid frame sent afterwards is received normally.
- R6: frame_err_o is 1 with the character when the stop-bit sample is 0. The character is still delivered.
- R7: The parameter PARITY selects the parity mode: 0 is none, 1 is even, 2 is odd. With even parity, parity_err_o is 1 when the data bits plus the parity bit hold an odd number of ones. With odd parity, it is 1 when they hold an even number.
- R8: Frames sent back to back, with one stop bit and no idle time, are all received, including frames whose last data bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, asynchronous, idles high |
| baud_inc_i | input | ACC_W | Accumulator increment per clock (used when USE_INC_PORT=1) |
| data_o | output | DATA_W | Received character |
| valid_o | output | 1 | One-cycle strobe marking a received character |
| frame_err_o | output | 1 | Stop-bit sample was 0 (qualified by valid_o) |
| parity_err_o | output | 1 | Parity mismatch (qualified by valid_o) |

## Verification
Every byte value is sent back to back at a 32-clock bit period into an even-parity receiver and an odd-parity receiver that share the line. A wrong bit order or a lost bit would corrupt data_o. A receiver that re-armed on a final 0 data bit would drop or garble the next frame. The odd receiver must flag every one of those frames, so a parity sense that was swapped or never checked shows up at once. Glitches of 5 and 7 ticks, a stop bit held low briefly, and a deliberate parity inversion target the glitch filter and the error flags: a missing filter would emit spurious characters, and a missed stop check would leave frame_err_o at 0. A final frame at half the rate exposes an accumulator that ignores baud_inc_i.

// File: rtl/uart_rx_16x_pkg.sv
package uart_rx_16x_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  localparam int unsigned PAR_NONE = 0;
  localparam int unsigned PAR_EVEN = 1;
  localparam int unsigned PAR_ODD  = 2;

  localparam logic [3:0] TICK_PRELOAD = 4'd8;
  localparam logic [3:0] TICK_LAST    = 4'd15;
endpackage

// File: rtl/uart_rx_16x_tick.sv
module uart_rx_16x_tick #(
  parameter int unsigned ACC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] inc_i,
  output logic             tick_o
);
  logic [ACC_W-1:0] acc_q;
  logic             tick_q;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, inc_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= sum[ACC_W-1:0];
      tick_q <= sum[ACC_W];
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/uart_rx_16x_sync.sv
module uart_rx_16x_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;   // line idles high
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_16x_core.sv
module uart_rx_16x_core
  import uart_rx_16x_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PARITY = PAR_EVEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              tick_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              frame_err_o,
  output logic              parity_err_o
);
  localparam int unsigned NBITS = DATA_W + ((PARITY != PAR_NONE) ? 1 : 0);
  localparam int unsigned BCW   = $clog2(NBITS + 1);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(NBITS - 1);

  rx_state_e         state_q;
  logic [3:0]        cnt_q;
  logic [BCW-1:0]    bit_q;
  logic [NBITS-1:0]  sr_q;
  logic [DATA_W-1:0] data_q;
  logic              valid_q, ferr_q, perr_q;
  logic              terminal;
  logic              par_bad;

  assign terminal = tick_i && (cnt_q == TICK_LAST);

  generate
    if (PARITY == PAR_NONE) begin : g_par_none
      assign par_bad = 1'b0;
    end else if (PARITY == PAR_EVEN) begin : g_par_even
      assign par_bad = ^sr_q;
    end else begin : g_par_odd
      assign par_bad = ~^sr_q;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= TICK_PRELOAD;
      bit_q   <= '0;
      sr_q    <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
      perr_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
      perr_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          cnt_q <= TICK_PRELOAD;
          bit_q <= '0;
          if (!rx_i) state_q <= ST_START;
        end
        ST_START: begin
          // line high before the centre: counter back to preload, no frame
          if (rx_i) begin
            state_q <= ST_IDLE;
            cnt_q   <= TICK_PRELOAD;
          end else if (tick_i) begin
            cnt_q <= cnt_q + 4'd1;
            if (cnt_q == TICK_LAST) state_q <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (tick_i) cnt_q <= cnt_q + 4'd1;
          if (terminal) begin
            sr_q <= {rx_i, sr_q[NBITS-1:1]};
            if (bit_q == LAST_BIT) begin
              state_q <= ST_STOP;
              bit_q   <= '0;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        ST_STOP: begin
          if (tick_i) cnt_q <= cnt_q + 4'd1;
          if (terminal) begin
            valid_q <= 1'b1;
            data_q  <= sr_q[DATA_W-1:0];
            ferr_q  <= !rx_i;
            perr_q  <= par_bad;
            state_q <= ST_IDLE;
            cnt_q   <= TICK_PRELOAD;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign data_o       = data_q;
  assign valid_o      = valid_q;
  assign frame_err_o  = ferr_q;
  assign parity_err_o = perr_q;
endmodule

// File: rtl/uart_rx_16x.sv
module uart_rx_16x
  import uart_rx_16x_pkg::*;
#(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned ACC_W        = 16,
  parameter int unsigned DEF_INC      = 32768,
  parameter bit          USE_INC_PORT = 1'b1,
  parameter int unsigned PARITY       = PAR_EVEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic [ACC_W-1:0]  baud_inc_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              frame_err_o,
  output logic              parity_err_o
);
  logic [ACC_W-1:0] inc_w;
  logic             tick_w;
  logic             rx_sync_w;

  generate
    if (USE_INC_PORT) begin : g_inc_port
      assign inc_w = baud_inc_i;
    end else begin : g_inc_param
      assign inc_w = ACC_W'(DEF_INC);
    end
  endgenerate

  uart_rx_16x_tick #(.ACC_W(ACC_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (inc_w),
    .tick_o (tick_w)
  );

  uart_rx_16x_sync #(.STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rx_i),
    .q_o    (rx_sync_w)
  );

  uart_rx_16x_core #(.DATA_W(DATA_W), .PARITY(PARITY)) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rx_i         (rx_sync_w),
    .tick_i       (tick_w),
    .data_o       (data_o),
    .valid_o      (valid_o),
    .frame_err_o  (frame_err_o),
    .parity_err_o (parity_err_o)
  );
endmodule

// File: rtl/uart_rx_16x_chk.sv
module uart_rx_16x_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              valid_i,
  input logic              frame_err_i,
  input logic              parity_err_i,
  input logic [DATA_W-1:0] data_i
);
  p_valid_one_cycle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

  p_flags_qualified_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (!frame_err_i && !parity_err_i));

  p_data_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> $stable(data_i));

  p_valid_on_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_i) |-> $past(tick_i));
endmodule

bind uart_rx_16x uart_rx_16x_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_w),
  .valid_i      (valid_o),
  .frame_err_i  (frame_err_o),
  .parity_err_i (parity_err_o),
  .data_i       (data_o)
);

// File: tb/uart_rx_16x_bench.sv
module uart_rx_16x_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx = 1'b1;
  logic [15:0] inc = 16'd32768;
  logic [7:0]  dat_e, dat_o;
  logic        val_e, val_o, fe_e, fe_o, pe_e, pe_o;

  int n_chk = 0;
  int n_fail = 0;
  int bit_clks = 32;

  int   cnt_e = 0, cnt_o = 0;
  logic [7:0] last_d;
  logic last_fe, last_pe, last_pe_odd;

  always #2.5 clk = ~clk;

  uart_rx_16x #(.PARITY(1)) u_uart_rx_16x (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .baud_inc_i(inc),
    .data_o(dat_e), .valid_o(val_e), .frame_err_o(fe_e), .parity_err_o(pe_e));

  uart_rx_16x #(.PARITY(2)) u_uart_rx_16x_odd (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .baud_inc_i(inc),
    .data_o(dat_o), .valid_o(val_o), .frame_err_o(fe_o), .parity_err_o(pe_o));

  always @(negedge clk) begin
    if (val_e) begin
      cnt_e++;
      last_d  = dat_e;
      last_fe = fe_e;
      last_pe = pe_e;
    end
    if (val_o) begin
      cnt_o++;
      last_pe_odd = pe_o;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic hold(input logic b, input int n);
    rx = b;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic par, input bit stop_ok);
    hold(1'b0, bit_clks);
    for (int i = 0; i < 8; i++) hold(d[i], bit_clks);
    hold(par, bit_clks);
    if (stop_ok) hold(1'b1, bit_clks);
    else begin
      hold(1'b0, bit_clks * 11 / 16);
      hold(1'b1, bit_clks - bit_clks * 11 / 16);
    end
    rx = 1'b1;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 190000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  initial begin
    int c0;
    repeat (10) @(negedge clk);
    chk("R1 valid in reset", int'(val_e), 0);
    chk("R1 data in reset", int'(dat_e), 0);
    chk("R1 flags in reset", int'(fe_e | pe_e), 0);
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    chk("R1 no char on idle line", cnt_e, 0);

    // all byte values back to back, even parity, R3/R7/R8
    for (int v = 0; v < 256; v++) begin
      c0 = cnt_e;
      send(8'(v), ^(8'(v)), 1'b1);
      chk("R8 one char per back-to-back frame", cnt_e, c0 + 1);
      chk("R3 data", int'(last_d), v);
      chk("R6 no framing error", int'(last_fe), 0);
      chk("R7 even parity ok", int'(last_pe), 0);
      chk("R7 odd receiver flags even frame", int'(last_pe_odd), 1);
    end
    chk("R4 single pulse per frame", cnt_o, 256);

    // wrong even parity
    repeat (40) @(negedge clk);
    c0 = cnt_e;
    send(8'hA5, ~(^8'hA5), 1'b1);
    chk("R4 bad parity frame counted", cnt_e, c0 + 1);
    chk("R7 even flags bad parity", int'(last_pe), 1);
    chk("R7 odd accepts", int'(last_pe_odd), 0);
    chk("R3 data with bad parity", int'(last_d), 8'hA5);

    // stop bit low
    c0 = cnt_e;
    send(8'h3C, ^8'h3C, 1'b0);
    repeat (4) @(negedge clk);
    chk("R6 framing error flagged", int'(last_fe), 1);
    chk("R6 data still delivered", int'(last_d), 8'h3C);
    repeat (200) @(negedge clk);
    chk("R5 no spurious char after short stop", cnt_e, c0 + 1);

    // glitches of 5 and 7 ticks
    c0 = cnt_e;
    hold(1'b0, 10);
    hold(1'b1, 300);
    chk("R5 5-tick glitch rejected", cnt_e, c0);
    hold(1'b0, 14);
    hold(1'b1, 300);
    chk("R5 7-tick glitch rejected", cnt_e, c0);
    send(8'h5A, ^8'h5A, 1'b1);
    chk("R5 recovery after glitch count", cnt_e, c0 + 1);
    chk("R5 recovery after glitch data", int'(last_d), 8'h5A);

    // half the rate via the increment input
    inc = 16'd16384;
    bit_clks = 64;
    repeat (200) @(negedge clk);
    c0 = cnt_e;
    send(8'hC3, ^8'hC3, 1'b1);
    chk("R2 slower rate count", cnt_e, c0 + 1);
    chk("R2 slower rate data", int'(last_d), 8'hC3);
    chk("R2 slower rate parity", int'(last_pe), 0);
    repeat (50) @(negedge clk);
    summary();
  end
endmodule